// File: doc/BRIEF.md
# Channel Trunk Conditioning Inserter

This block sits in the transmit path of a T1/J1 line, ahead of the framing generator. It handles one channel octet per valid beat. Each beat is tagged with its channel number (0 to 23) and its frame number within the multiframe (0-based). On each beat the block can do two things. It can overwrite the whole octet with a programmed idle code, and it can overwrite the robbed-bit signaling position with bits from another source. That source is a parallel signaling input that arrives alongside each octet, or fixed A/B/C/D values held for the channel.

A bank of 24 per-channel entries holds the settings. Each entry has an idle code, a 2-bit signaling source select, the A/B/C/D bits and a conditioning flag, and is loaded through a single write port. A global enable gates every per-channel override. When it is low, the stream passes through untouched.

An optional hold mode keeps signaling stable across a multiframe. It latches each channel's signaling at that channel's beat in the first frame and uses the latched bits for the rest of the multiframe. This stops a signaling change from landing in the middle of a multiframe.

Top module: `chan_cond_inserter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock, and `out_data` carries the processed octet of that beat. Reset clears both to zero.
- R2: With `ctl_en` low, `out_data` equals the input octet whatever the bank holds.
- R3: With `ctl_en` high and the channel's conditioning flag set, all 8 bits of the octet are replaced by the channel's idle code. The signaling bit is the exception when R6 applies.
- R4: Signaling slots are bit 0 of the octet in frames 5 and 11 (0-based) in superframe mode (`esf_mode`=0), carrying A then B. In extended mode (`esf_mode`=1) they are frames 5, 11, 17 and 23, carrying A, B, C, D. Bit 0 in any other frame is never altered by signaling.
- R5: Source select encoding: 00 keeps the stream bit, 01 takes `in_sig`, 10 takes the entry's stored bits, 11 behaves as 00. Both `in_sig` and the stored bits order A, B, C, D from bit 3 down to bit 0.
- R6: In a signaling slot with select 01 or 10 and `ctl_en` high, the signaling bit overrides bit 0 of the idle code as well as bit 0 of the stream octet.
- R7: With `freeze_en` high, the signaling bit in each slot is taken from the bits captured at that channel's frame-0 beat of the current multiframe. The capture comes from the source the select chose at that beat.
- R8: Write data layout is [14:7] idle code, [6:5] select, [4:1] A/B/C/D (A at bit 4), [0] conditioning flag. A write takes effect from the next beat. A beat in the same cycle as a write to its own channel uses the old entry.
- R9: Beats with a channel number of 24 or more pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Global enable for per-channel overrides |
| esf_mode | input | 1 | 1 = 24-frame extended multiframe, 0 = 12-frame superframe |
| freeze_en | input | 1 | Hold signaling at the multiframe's first-frame values |
| in_valid | input | 1 | Octet beat present |
| in_data | input | 8 | Channel octet from the stream |
| in_chan | input | 5 | Channel number of the beat |
| in_frame | input | 5 | 0-based frame number within the multiframe |
| in_sig | input | 4 | Signaling bits A..D for this channel (A at bit 3) |
| cfg_we | input | 1 | Bank write strobe |
| cfg_addr | input | 5 | Bank entry to write |
| cfg_wdata | input | 15 | Entry contents, layout in R8 |
| out_valid | output | 1 | Processed octet present |
| out_data | output | 8 | Processed octet |

## Verification
The two functions that can meet in one cycle are a bank write and a stream beat for the same channel. The write must not reach the octet already being processed. The bench raises `cfg_we` for channel 4 in the very cycle a channel-4 beat is presented. It then expects the old pass-through octet on that beat and the new idle code on the following channel-4 beat. The bench also drives the idle code and the signaling override on the same octet in a signaling slot, and judges the result by bit 0 alone differing from the idle code.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int unsigned CH_COUNT   = 24;
    localparam int unsigned IDLE_W     = 8;
    localparam int unsigned SIG_W      = 4;
    localparam int unsigned FRAME_W    = 5;
    localparam int unsigned SIG_PERIOD = 6;

    typedef enum logic [1:0] {
        SIG_PASS     = 2'b00,
        SIG_SERIAL   = 2'b01,
        SIG_REGS     = 2'b10,
        SIG_PASS_ALT = 2'b11
    } sig_sel_e;

    typedef struct packed {
        logic [IDLE_W-1:0] idle;
        sig_sel_e          sel;
        logic [SIG_W-1:0]  abcd;
        logic              tc;
    } chan_cfg_t;

    localparam int unsigned CFG_W = $bits(chan_cfg_t);

    typedef struct packed {
        logic       hit;
        logic [1:0] idx;
    } sig_slot_t;

    // Locate the robbed-bit slot for a 0-based frame number.
    function automatic sig_slot_t slot_of(logic [FRAME_W-1:0] frame, logic esf);
        sig_slot_t s;
        int f1;
        int last;
        s    = '0;
        f1   = int'(frame) + 1;
        last = (esf ? 4 : 2) * int'(SIG_PERIOD);
        if ((f1 % int'(SIG_PERIOD)) == 0 && f1 <= last) begin
            s.hit = 1'b1;
            s.idx = 2'(f1 / int'(SIG_PERIOD) - 1);
        end
        return s;
    endfunction

    function automatic logic sel_overrides(sig_sel_e sel);
        return (sel == SIG_SERIAL) || (sel == SIG_REGS);
    endfunction

endpackage

// File: rtl/ctc_cfg_bank.sv
module ctc_cfg_bank
    import ctc_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned AW  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  chan_cfg_t       wr_data,
    input  logic [AW-1:0]   rd_addr,
    output chan_cfg_t       rd_data,
    output logic            rd_hit
);

    localparam logic [AW-1:0] LAST_IDX = AW'(NCH - 1);

    chan_cfg_t entries [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entries[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                entries[g] <= wr_data;
        end

        p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == AW'(g)) |=> (entries[g] == $past(wr_data)));
    end

    always_comb begin
        rd_hit  = (rd_addr <= LAST_IDX);
        rd_data = rd_hit ? entries[rd_addr] : '0;
    end

endmodule

// File: rtl/ctc_sig_hold.sv
module ctc_sig_hold
    import ctc_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned AW  = $clog2(NCH),
    parameter int unsigned SW  = SIG_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cap_en,
    input  logic [AW-1:0]  cap_chan,
    input  logic [SW-1:0]  cap_bits,
    input  logic [AW-1:0]  rd_chan,
    output logic [SW-1:0]  rd_bits
);

    localparam logic [AW-1:0] LAST_IDX = AW'(NCH - 1);

    logic [SW-1:0] held [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)
                held[g] <= '0;
            else if (cap_en && cap_chan == AW'(g))
                held[g] <= cap_bits;
        end

        p_capture_r7: assert property (@(posedge clk) disable iff (rst)
            (cap_en && cap_chan == AW'(g)) |=> (held[g] == $past(cap_bits)));
    end

    assign rd_bits = (rd_chan <= LAST_IDX) ? held[rd_chan] : '0;

endmodule

// File: rtl/ctc_octet_mux.sv
module ctc_octet_mux
    import ctc_pkg::*;
#(
    parameter int unsigned DW = IDLE_W,
    parameter int unsigned SW = SIG_W,
    parameter int unsigned FW = FRAME_W
) (
    input  logic          en,
    input  logic          in_range,
    input  logic          esf,
    input  logic          freeze,
    input  chan_cfg_t     cfg,
    input  logic [DW-1:0] data_i,
    input  logic [SW-1:0] sig_i,
    input  logic [SW-1:0] held_i,
    input  logic [FW-1:0] frame,
    output logic [DW-1:0] data_o
);

    sig_slot_t     slot;
    logic          active;
    logic [SW-1:0] src;
    int            bit_sel;

    always_comb begin
        slot    = slot_of(frame, esf);
        active  = en && in_range;
        src     = freeze ? held_i : ((cfg.sel == SIG_SERIAL) ? sig_i : cfg.abcd);
        bit_sel = int'(SW) - 1 - int'(slot.idx);
        data_o  = (active && cfg.tc) ? cfg.idle : data_i;
        if (active && slot.hit && sel_overrides(cfg.sel))
            data_o[0] = src[bit_sel];
    end

endmodule

// File: rtl/chan_cond_inserter.sv
module chan_cond_inserter
    import ctc_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned DW  = IDLE_W,
    parameter int unsigned SW  = SIG_W,
    parameter int unsigned FW  = FRAME_W,
    parameter int unsigned AW  = $clog2(NCH),
    parameter int unsigned CW  = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_en,
    input  logic          esf_mode,
    input  logic          freeze_en,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [AW-1:0] in_chan,
    input  logic [FW-1:0] in_frame,
    input  logic [SW-1:0] in_sig,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    chan_cfg_t     rd_cfg;
    logic          rd_hit;
    logic [SW-1:0] held_bits;
    logic [SW-1:0] cap_bits;
    logic          cap_en;
    logic [DW-1:0] mux_data;
    sig_slot_t     cur_slot;

    ctc_cfg_bank #(.NCH(NCH), .AW(AW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (chan_cfg_t'(cfg_wdata)),
        .rd_addr (in_chan),
        .rd_data (rd_cfg),
        .rd_hit  (rd_hit)
    );

    always_comb begin
        cap_en   = in_valid && rd_hit && (in_frame == '0);
        cap_bits = (rd_cfg.sel == SIG_SERIAL) ? in_sig : rd_cfg.abcd;
        cur_slot = slot_of(in_frame, esf_mode);
    end

    ctc_sig_hold #(.NCH(NCH), .AW(AW), .SW(SW)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_chan (in_chan),
        .cap_bits (cap_bits),
        .rd_chan  (in_chan),
        .rd_bits  (held_bits)
    );

    ctc_octet_mux #(.DW(DW), .SW(SW), .FW(FW)) u_mux (
        .en       (ctl_en),
        .in_range (rd_hit),
        .esf      (esf_mode),
        .freeze   (freeze_en),
        .cfg      (rd_cfg),
        .data_i   (in_data),
        .sig_i    (in_sig),
        .held_i   (held_bits),
        .frame    (in_frame),
        .data_o   (mux_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= mux_data;
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_pass_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl_en) |=> (out_data == $past(in_data)));

    p_idle_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_en && rd_hit && rd_cfg.tc && !cur_slot.hit)
            |=> (out_data == $past(rd_cfg.idle)));

    p_nonslot_lsb_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cur_slot.hit && !(ctl_en && rd_hit && rd_cfg.tc))
            |=> (out_data[0] == $past(in_data[0])));

    p_upper_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_en && rd_hit && rd_cfg.tc)
            |=> (out_data[DW-1:1] == $past(rd_cfg.idle[DW-1:1])));

    p_out_of_range_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rd_hit) |=> (out_data == $past(in_data)));

endmodule

// File: tb/chan_cond_inserter_tb_top.sv
module chan_cond_inserter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_en, esf_mode, freeze_en;
    logic        in_valid;
    logic [7:0]  in_data;
    logic [4:0]  in_chan, in_frame;
    logic [3:0]  in_sig;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [14:0] cfg_wdata;
    logic        out_valid;
    logic [7:0]  out_data;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    chan_cond_inserter dut_i (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .esf_mode(esf_mode),
        .freeze_en(freeze_en), .in_valid(in_valid), .in_data(in_data),
        .in_chan(in_chan), .in_frame(in_frame), .in_sig(in_sig),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [14:0] pack_cfg(logic [7:0] idle, logic [1:0] sel,
                                             logic [3:0] abcd, logic tc);
        return {idle, sel, abcd, tc};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [4:0] addr, logic [14:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Drive one beat and return the octet that appears one clock later.
    task automatic beat(logic [4:0] ch, logic [4:0] fr, logic [7:0] d,
                        logic [3:0] s, output logic [7:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_chan = ch; in_frame = fr; in_data = d; in_sig = s;
        @(posedge clk); #1;
        res = out_data;
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset valid", {7'd0, out_valid}, 8'h00);
        check("R1 reset data", out_data, 8'h00);
    endtask

    task automatic t_passthrough();
        logic [7:0] r;
        ctl_en = 1'b0;
        write_cfg(5'd3, pack_cfg(8'h55, 2'b10, 4'b0110, 1'b1));
        beat(5'd3, 5'd5, 8'hA2, 4'hF, r);
        check("R2 disabled pass", r, 8'hA2);
        check("R1 valid follows", {7'd0, out_valid}, 8'h01);
        @(posedge clk); #1;
        check("R1 valid drops", {7'd0, out_valid}, 8'h00);
    endtask

    task automatic t_idle();
        logic [7:0] r;
        ctl_en = 1'b1; esf_mode = 1'b0;
        beat(5'd3, 5'd0, 8'hA2, 4'h0, r);
        check("R3 idle fill", r, 8'h55);
        beat(5'd3, 5'd5, 8'hA2, 4'hF, r);
        check("R6 A over idle", r, 8'h54);
        beat(5'd3, 5'd11, 8'hA2, 4'h0, r);
        check("R6 B over idle", r, 8'h55);
    endtask

    task automatic t_sig_sf();
        logic [7:0] r;
        esf_mode = 1'b0;
        write_cfg(5'd7, pack_cfg(8'h00, 2'b01, 4'b0000, 1'b0));
        beat(5'd7, 5'd5, 8'h00, 4'b1000, r);
        check("R4 SF A slot serial", r, 8'h01);
        beat(5'd7, 5'd11, 8'hFF, 4'b1011, r);
        check("R4 SF B slot serial", r, 8'hFE);
        beat(5'd7, 5'd4, 8'hFE, 4'b1111, r);
        check("R4 non-slot frame", r, 8'hFE);
        beat(5'd7, 5'd17, 8'h00, 4'b1111, r);
        check("R4 SF has no C slot", r, 8'h00);
    endtask

    task automatic t_sig_esf();
        logic [7:0] r;
        esf_mode = 1'b1;
        write_cfg(5'd7, pack_cfg(8'h00, 2'b10, 4'b0011, 1'b0));
        beat(5'd7, 5'd17, 8'h00, 4'h0, r);
        check("R4 ESF C slot regs", r, 8'h01);
        beat(5'd7, 5'd23, 8'h00, 4'h0, r);
        check("R4 ESF D slot regs", r, 8'h01);
        beat(5'd7, 5'd5, 8'hFF, 4'hF, r);
        check("R5 regs A slot", r, 8'hFE);
        beat(5'd7, 5'd12, 8'h00, 4'hF, r);
        check("R4 ESF non-slot", r, 8'h00);
    endtask

    task automatic t_sel11();
        logic [7:0] r;
        esf_mode = 1'b1;
        write_cfg(5'd9, pack_cfg(8'h00, 2'b11, 4'b1111, 1'b0));
        beat(5'd9, 5'd5, 8'h10, 4'hF, r);
        check("R5 select 11 keeps stream", r, 8'h10);
    endtask

    task automatic t_freeze();
        logic [7:0] r;
        esf_mode = 1'b1; freeze_en = 1'b1;
        write_cfg(5'd2, pack_cfg(8'h00, 2'b01, 4'b0000, 1'b0));
        beat(5'd2, 5'd0, 8'h33, 4'b1010, r);
        check("R7 capture frame keeps data", r, 8'h33);
        beat(5'd2, 5'd5, 8'h00, 4'b0000, r);
        check("R7 frozen A", r, 8'h01);
        beat(5'd2, 5'd11, 8'hFF, 4'b1111, r);
        check("R7 frozen B", r, 8'hFE);
        beat(5'd2, 5'd17, 8'h00, 4'b0000, r);
        check("R7 frozen C", r, 8'h01);
        beat(5'd2, 5'd0, 8'h33, 4'b0101, r);
        beat(5'd2, 5'd5, 8'hFF, 4'b1111, r);
        check("R7 next multiframe A", r, 8'hFE);
        freeze_en = 1'b0;
    endtask

    task automatic t_collision();
        logic [7:0] r;
        ctl_en = 1'b1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'd4;
        cfg_wdata = pack_cfg(8'hC3, 2'b00, 4'b0000, 1'b1);
        in_valid = 1'b1; in_chan = 5'd4; in_frame = 5'd1; in_data = 8'h18; in_sig = 4'h0;
        @(posedge clk); #1;
        cfg_we = 1'b0; in_valid = 1'b0;
        check("R8 same-cycle write uses old entry", out_data, 8'h18);
        beat(5'd4, 5'd2, 8'h18, 4'h0, r);
        check("R8 write applies next beat", r, 8'hC3);
    endtask

    task automatic t_out_of_range();
        logic [7:0] r;
        ctl_en = 1'b1;
        beat(5'd26, 5'd5, 8'h5A, 4'hF, r);
        check("R9 channel 26 passes", r, 8'h5A);
    endtask

    initial begin
        rst = 1'b1; ctl_en = 1'b0; esf_mode = 1'b0; freeze_en = 1'b0;
        in_valid = 1'b0; in_data = '0; in_chan = '0; in_frame = '0; in_sig = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_passthrough();
        t_idle();
        t_sig_sf();
        t_sig_esf();
        t_sel11();
        t_freeze();
        t_collision();
        t_out_of_range();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule